// File: doc/BRIEF.md
# Telecom frame pulse generator

This block takes a single 32.768 MHz master clock and derives from it the 8 kHz frame-start markers needed by several serial backplane buses, together with 4.096 MHz and 2.048 MHz bit clocks. Each marker has its own width and polarity, sized to the bus rate it serves. All markers and both bit clocks line up on one shared frame boundary.

A single free-running frame counter wraps every 4096 master cycles. Each output is decoded from that count and registered, so every output changes on the same rising edge. A synchronous reset and an enable both clear the counter and force all outputs to their idle levels. When the enable is raised again, a new frame starts on the next edge.

Top module: `frame_pulse_gen`

## Requirements
- R1: The frame lasts 4096 master cycles. Counting rising edges while enabled from k=0, the first edge after enable rises is k=0. The frame start appears on the outputs at that edge and again at every k that is a multiple of 4096.
- R2: `fs_short_n` is low only on the edge with k mod 4096 = 0, which makes it one cycle wide. It is high on every other edge.
- R3: `fs_dbl_n` is low for k mod 4096 < 2 and high otherwise.
- R4: `fs_quad` is high for k mod 4096 < 4 and low otherwise.
- R5: `fs_oct_n` is low for k mod 4096 < 8 and high otherwise.
- R6: `fs_sync` is the receive/transmit sync marker. It is high for k mod 4096 < 16 and low otherwise.
- R7: `bclk_4m` is high when k mod 8 < 4 and low otherwise. This divides the master clock by 8, with each period starting at the frame start.
- R8: `bclk_2m` is high when k mod 16 < 8 and low otherwise. This divides the master clock by 16 and is aligned with `bclk_4m`.
- R9: On any edge where `rst` is high or `en` is low, the counter clears. All outputs take the idle vector: the active-low markers high, the active-high markers low and both clocks low. This holds even when that edge would have been a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 MHz master clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low clears and idles |
| fs_short_n | output | 1 | Frame start, 1 cycle, active low |
| fs_dbl_n | output | 1 | Frame start, 2 cycles, active low |
| fs_quad | output | 1 | Frame start, 4 cycles, active high |
| fs_oct_n | output | 1 | Frame start, 8 cycles, active low |
| fs_sync | output | 1 | Rx/Tx sync, 16 cycles, active high |
| bclk_4m | output | 1 | Master clock divided by 8 |
| bclk_2m | output | 1 | Master clock divided by 16 |

## Verification
The frame wrap and a disable can land on the same edge. At that edge the counter would start a new frame, but the clear has to take priority. The bench runs to k=4095 and drops `en` just before the wrap edge. It then requires the idle vector on that edge rather than the frame-start vector, which differs from it in every bit. It also drops `en` in the middle of the markers to show that the clear cuts pulses short on the following edge.

// File: rtl/frame_pulse_gen.sv
module frame_pulse_gen #(
  parameter int FRAME_BITS = 12,
  parameter int W_SHORT    = 1,
  parameter int W_DBL      = 2,
  parameter int W_QUAD     = 4,
  parameter int W_OCT      = 8,
  parameter int W_SYNC     = 16,
  parameter int DIV_FAST   = 3,
  parameter int DIV_SLOW   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic fs_short_n,
  output logic fs_dbl_n,
  output logic fs_quad,
  output logic fs_oct_n,
  output logic fs_sync,
  output logic bclk_4m,
  output logic bclk_2m
);

  localparam logic [FRAME_BITS-1:0] LIM_SHORT = FRAME_BITS'(W_SHORT);
  localparam logic [FRAME_BITS-1:0] LIM_DBL   = FRAME_BITS'(W_DBL);
  localparam logic [FRAME_BITS-1:0] LIM_QUAD  = FRAME_BITS'(W_QUAD);
  localparam logic [FRAME_BITS-1:0] LIM_OCT   = FRAME_BITS'(W_OCT);
  localparam logic [FRAME_BITS-1:0] LIM_SYNC  = FRAME_BITS'(W_SYNC);

  logic [FRAME_BITS-1:0] cnt;
  logic                  clr;

  assign clr = rst || !en;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt        <= '0;
      fs_short_n <= 1'b1;
      fs_dbl_n   <= 1'b1;
      fs_quad    <= 1'b0;
      fs_oct_n   <= 1'b1;
      fs_sync    <= 1'b0;
      bclk_4m    <= 1'b0;
      bclk_2m    <= 1'b0;
    end else begin
      cnt        <= cnt + 1'b1;
      fs_short_n <= !(cnt < LIM_SHORT);
      fs_dbl_n   <= !(cnt < LIM_DBL);
      fs_quad    <= cnt < LIM_QUAD;
      fs_oct_n   <= !(cnt < LIM_OCT);
      fs_sync    <= cnt < LIM_SYNC;
      bclk_4m    <= !cnt[DIV_FAST-1];
      bclk_2m    <= !cnt[DIV_SLOW-1];
    end
  end

endmodule

// File: rtl/frame_pulse_gen_chk.sv
module frame_pulse_gen_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic fs_short_n,
  input logic fs_dbl_n,
  input logic fs_quad,
  input logic fs_oct_n,
  input logic fs_sync,
  input logic bclk_4m,
  input logic bclk_2m
);

  p_idle_when_off_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (fs_short_n && fs_dbl_n && !fs_quad && fs_oct_n && !fs_sync && !bclk_4m && !bclk_2m));

  p_start_nests_r2: assert property (@(posedge clk) disable iff (rst)
    !fs_short_n |-> (!fs_dbl_n && fs_quad && !fs_oct_n && fs_sync && bclk_4m && bclk_2m));

  p_short_single_r2: assert property (@(posedge clk) disable iff (rst)
    !fs_short_n |=> fs_short_n);

  p_dbl_two_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(fs_dbl_n) && en) |=> !fs_dbl_n);

  p_quad_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(fs_quad) && en) |=> fs_quad);

  p_slow_with_fast_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(bclk_2m) |-> bclk_4m);

  p_fast_period_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(bclk_4m) && en) |=> bclk_4m);

endmodule

bind frame_pulse_gen frame_pulse_gen_chk u_chk (.*);

// File: tb/frame_pulse_gen_test.sv
module frame_pulse_gen_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic fs_short_n, fs_dbl_n, fs_quad, fs_oct_n, fs_sync, bclk_4m, bclk_2m;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [6:0] IDLE = 7'b1101000;
  localparam int NV = 12;
  localparam int VK [NV] = '{0, 1, 2, 3, 4, 7, 8, 12, 15, 16, 4095, 4096};
  localparam logic [6:0] VE [NV] = '{7'b0010111, 7'b1010111, 7'b1110111, 7'b1110111,
                                     7'b1100101, 7'b1100101, 7'b1101110, 7'b1101100,
                                     7'b1101100, 7'b1101011, 7'b1101000, 7'b0010111};
  localparam string VT [NV] = '{"R1 R2", "R2 R3", "R3 R4", "R4", "R4 R7", "R5 R7",
                                "R5 R8", "R6 R7", "R6 R8", "R6 R8", "R1 R7", "R1 R2"};

  always #2 clk = ~clk;

  frame_pulse_gen uut (.*);

  function automatic logic [6:0] model(int k);
    int m = k % 4096;
    return {m >= 1, m >= 2, m < 4, m >= 8, m < 16, (k % 8) < 4, (k % 16) < 8};
  endfunction

  function automatic logic [6:0] outs();
    return {fs_short_n, fs_dbl_n, fs_quad, fs_oct_n, fs_sync, bclk_4m, bclk_2m};
  endfunction

  task automatic chk(input logic [6:0] exp, input string tag);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s got %b exp %b", tag, outs(), exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step();
    chk(IDLE, "R9 reset state");
    rst = 1'b0;
    step();
    chk(IDLE, "R9 disabled after reset");

    en = 1'b1;
    for (int k = 0; k < 4200; k++) begin
      step();
      chk(model(k), $sformatf("R2 R3 R4 R5 R6 R7 R8 sweep k=%0d", k));
      for (int v = 0; v < NV; v++)
        if (VK[v] == k) chk(VE[v], $sformatf("%s vector k=%0d", VT[v], k));
    end

    en = 1'b0;
    step();
    chk(IDLE, "R9 disable idles");
    en = 1'b1;
    step();
    chk(7'b0010111, "R1 restart at frame start");
    for (int k = 1; k <= 5; k++) step();
    en = 1'b0;
    step();
    chk(IDLE, "R9 disable mid pulse");

    en = 1'b1;
    for (int k = 0; k <= 4095; k++) step();
    chk(7'b1101000, "R1 k=4095 before wrap");
    en = 1'b0;
    step();
    chk(IDLE, "R9 disable on wrap edge");
    en = 1'b1;
    step();
    chk(7'b0010111, "R1 frame start after wrap disable");
    step();
    chk(7'b1010111, "R2 k=1 after restart");

    rst = 1'b1;
    step();
    chk(IDLE, "R9 reset while enabled");
    rst = 1'b0;
    step();
    chk(7'b0010111, "R1 frame start after reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule